// File: doc/BRIEF.md
# Soft-Stepped Gain Controller

This block sits between a software-written gain request and a programmable-gain stage. It does not let the stage's gain jump. It moves the applied gain one half-decibel code per sample strobe toward the requested code. It raises a settled flag once the applied gain matches the request. A bypass input can disable stepping, and the applied gain then takes the requested value at the next clock edge.

When a power-down is requested, the target becomes a dedicated mute level that lies one step below code 0. The applied gain walks down to that level. A busy flag stays high until mute is reached, and the clock must keep running while the flag is high. When the power-down request is withdrawn, the gain walks back up from its current level to the request. If the request changes during a ramp, stepping continues from the current applied value toward the new target.

Top module: `soft_gain_ctrl`

## Requirements
- R1: After a synchronous active-low reset the output is muted (gain_mute=1, gain_code=0), settled is low and pdn_busy is low.
- R2: With step_bypass low, the applied level changes by exactly one step toward the target on each clock edge where sample_tick is high and the level differs from the target. It does not change on edges where sample_tick is low.
- R3: settled is high exactly when the output is not muted and gain_code equals gain_req.
- R4: With step_bypass high, the applied level equals the target after the next clock edge, whatever the distance and whatever sample_tick is.
- R5: While pdn_req is high the target is mute, and the applied level never rises.
- R6: pdn_busy is high exactly while pdn_req is high and the output is not yet muted. It falls only once mute is reached.
- R7: If gain_req changes during a ramp, stepping continues from the present applied value toward the new request, without restarting.
- R8: When pdn_req is released, the gain ramps up from its current level (mute, if it got there) through code 0 to gain_req.
- R9: gain_code is a 7-bit value in 0.5 dB units. Mute is shown as gain_mute=1 with gain_code=0. The step above mute is code 0 with gain_mute=0, so the walk from mute up to code N takes N+1 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle sample strobe that permits one step |
| gain_req | input | 7 | Requested gain code, 0.5 dB units |
| step_bypass | input | 1 | 1 = jump straight to target, 0 = soft step |
| pdn_req | input | 1 | Power-down request; target becomes mute |
| gain_code | output | 7 | Applied gain code (0 while muted) |
| gain_mute | output | 1 | Applied gain is at the mute level |
| settled | output | 1 | Applied gain equals the request |
| pdn_busy | output | 1 | Power-down ramp still in progress |

## Verification
The assertions treat sample_tick, step_bypass, pdn_req and gain_req as synchronous inputs that are stable around each clock edge. They do not assume that sample_tick is a single-cycle pulse or that it has any particular spacing. The bench drives every input on the falling edge and holds it through the next rising edge. The sweeps mix strobed and unstrobed cycles, change the request during ramps and toggle bypass and power-down at arbitrary levels, so every assertion's antecedent is reached within these input rules.

// File: rtl/gss_pkg.sv
// Shared types for the soft-stepped gain controller.
// Assumes nothing beyond the IEEE 1800-2017 language.
package gss_pkg;
    // Direction of the next step of the applied level
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;
endpackage

// File: rtl/gss_target.sv
// Chooses the level the stepper heads for: mute (level 0) under power-down,
// otherwise the requested code shifted up by one so that mute sits below code 0.
// Assumes gain_req is a plain binary code in 0.5 dB units.
module gss_target #(
    parameter int GAIN_W = 7,
    localparam int LW = GAIN_W + 1
) (
    input  logic [GAIN_W-1:0] gain_req,
    input  logic              pdn_req,
    output logic [LW-1:0]     tgt_lvl
);
    // Map the request into level space, or force mute under power-down
    always_comb begin
        if (pdn_req) tgt_lvl = '0;
        else         tgt_lvl = LW'(gain_req) + LW'(1);
    end
endmodule

// File: rtl/gss_stepper.sv
// Holds the applied level and moves it one step per sample strobe toward the
// target, or loads the target directly when bypass is set.
// Assumes inputs are synchronous to clk; reset is synchronous, active low.
module gss_stepper
    import gss_pkg::*;
#(
    parameter int GAIN_W = 7,
    localparam int LW = GAIN_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_tick,
    input  logic          step_bypass,
    input  logic [LW-1:0] tgt_lvl,
    output logic [LW-1:0] lvl
);
    step_dir_e     dir;
    logic [LW-1:0] lvl_nxt;

    // Decide the step direction from the current level and the target
    always_comb begin
        if (lvl < tgt_lvl)      dir = DIR_UP;
        else if (lvl > tgt_lvl) dir = DIR_DOWN;
        else                    dir = DIR_HOLD;
    end

    // Form the next level from bypass, strobe and direction
    always_comb begin
        lvl_nxt = lvl;
        if (step_bypass) begin
            lvl_nxt = tgt_lvl;
        end else if (sample_tick) begin
            case (dir)
                DIR_UP:   lvl_nxt = lvl + LW'(1);
                DIR_DOWN: lvl_nxt = lvl - LW'(1);
                default:  lvl_nxt = lvl;
            endcase
        end
    end

    // Level register, muted at reset
    always_ff @(posedge clk) begin
        if (!rst_n) lvl <= '0;
        else        lvl <= lvl_nxt;
    end

    // R2: with soft stepping, one edge moves the level by at most one step
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step_bypass |=> (lvl == $past(lvl)) || (lvl == $past(lvl) + 1'b1)
                         || (lvl == $past(lvl) - 1'b1));

    // R2: no strobe and no bypass means the level holds
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_tick && !step_bypass) |=> $stable(lvl));

    // R4: bypass lands on the target in one edge
    a_r4_bypass_lands: assert property (@(posedge clk) disable iff (!rst_n)
        step_bypass |=> lvl == $past(tgt_lvl));

    // R5: heading for mute, the level never rises
    a_r5_no_rise_in_pdn: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_lvl == '0) |=> lvl <= $past(lvl));
endmodule

// File: rtl/gss_status.sv
// Decodes the applied level into the stage's gain code and mute bit, and
// produces the settled and power-down-busy flags.
// Assumes level 0 is mute and level k+1 is gain code k.
module gss_status #(
    parameter int GAIN_W = 7,
    localparam int LW = GAIN_W + 1
) (
    input  logic [LW-1:0]     lvl,
    input  logic [GAIN_W-1:0] gain_req,
    input  logic              pdn_req,
    output logic [GAIN_W-1:0] gain_code,
    output logic              gain_mute,
    output logic              settled,
    output logic              pdn_busy
);
    logic [LW-1:0] lvl_less;

    // Convert level to code; mute shows code 0
    always_comb begin
        lvl_less  = lvl - LW'(1);
        gain_mute = (lvl == '0);
        gain_code = gain_mute ? '0 : lvl_less[GAIN_W-1:0];
    end

    // Flags for the register interface
    always_comb begin
        settled  = !gain_mute && (gain_code == gain_req);
        pdn_busy = pdn_req && !gain_mute;
    end
endmodule

// File: rtl/soft_gain_ctrl.sv
// Top of the soft-stepped gain controller: target selection, the stepping
// register and output decode. Assumes all inputs are synchronous to clk.
module soft_gain_ctrl #(
    parameter int GAIN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic [GAIN_W-1:0] gain_req,
    input  logic              step_bypass,
    input  logic              pdn_req,
    output logic [GAIN_W-1:0] gain_code,
    output logic              gain_mute,
    output logic              settled,
    output logic              pdn_busy
);
    localparam int LW = GAIN_W + 1;

    logic [LW-1:0] tgt_lvl;
    logic [LW-1:0] lvl;

    gss_target #(.GAIN_W(GAIN_W)) u_target (
        .gain_req (gain_req),
        .pdn_req  (pdn_req),
        .tgt_lvl  (tgt_lvl)
    );

    gss_stepper #(.GAIN_W(GAIN_W)) u_stepper (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .step_bypass (step_bypass),
        .tgt_lvl     (tgt_lvl),
        .lvl         (lvl)
    );

    gss_status #(.GAIN_W(GAIN_W)) u_status (
        .lvl       (lvl),
        .gain_req  (gain_req),
        .pdn_req   (pdn_req),
        .gain_code (gain_code),
        .gain_mute (gain_mute),
        .settled   (settled),
        .pdn_busy  (pdn_busy)
    );

    // R6: busy may drop under a held power-down only once muted
    a_r6_busy_ends_muted: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_req && $past(pdn_req) && $fell(pdn_busy)) |-> gain_mute);

    // R9: the mute level always shows code 0
    a_r9_mute_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        gain_mute |-> gain_code == '0);

    // R3: a settled stage is never muted
    a_r3_settled_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> !gain_mute);
endmodule

// File: tb/sim_soft_gain_ctrl.sv
module sim_soft_gain_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] req = '0;
    logic       byp = 1'b0;
    logic       pdn = 1'b0;
    logic [6:0] gain_code;
    logic       gain_mute, settled, pdn_busy;

    int checks = 0;
    int fails  = 0;
    int mlvl   = 0;

    always #4 clk = ~clk;

    soft_gain_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sample_tick(tick), .gain_req(req),
        .step_bypass(byp), .pdn_req(pdn), .gain_code(gain_code),
        .gain_mute(gain_mute), .settled(settled), .pdn_busy(pdn_busy)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d lvl=%0d", tag, what, act, exp, mlvl);
        end
    endtask

    // one clock: drive on negedge, update model at posedge, compare after it
    task automatic drive(input logic [6:0] rq, input logic tk, input logic by,
                         input logic pd, input string tag);
        int t, emute, ecode;
        @(negedge clk);
        req = rq; tick = tk; byp = by; pdn = pd;
        @(posedge clk);
        t = pd ? 0 : int'(rq) + 1;
        if (!rst_n)     mlvl = 0;
        else if (by)    mlvl = t;
        else if (tk) begin
            if (mlvl < t)      mlvl = mlvl + 1;
            else if (mlvl > t) mlvl = mlvl - 1;
        end
        #1;
        emute = (mlvl == 0) ? 1 : 0;
        ecode = emute ? 0 : mlvl - 1;
        chk(tag, "gain_code", int'(gain_code), ecode);
        chk(tag, "gain_mute", int'(gain_mute), emute);
        chk("R3", "settled", int'(settled), (!emute && ecode == int'(rq)) ? 1 : 0);
        chk("R6", "pdn_busy", int'(pdn_busy), (pd && !emute) ? 1 : 0);
    endtask

    task automatic ramp(input logic [6:0] rq, input logic pd, input string tag);
        int t;
        t = pd ? 0 : int'(rq) + 1;
        for (int i = 0; i < 400; i++) begin
            if (mlvl == t) break;
            drive(rq, (i % 2) == 0, 1'b0, pd, tag);
        end
        chk(tag, "reached", mlvl, t);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=running expected=done");
        summary();
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        drive(7'd50, 1'b1, 1'b0, 1'b0, "R1");
        drive(7'd50, 1'b1, 1'b0, 1'b0, "R1");
        chk("R1", "mute_at_reset", int'(gain_mute), 1);
        chk("R1", "busy_at_reset", int'(pdn_busy), 0);
        rst_n = 1'b1;

        // R9/R2: first step above mute is code 0
        drive(7'd3, 1'b0, 1'b0, 1'b0, "R2");
        drive(7'd3, 1'b1, 1'b0, 1'b0, "R9");
        chk("R9", "first_step_code0", int'(gain_code) + 2 * int'(gain_mute), 0);

        // R2/R8/R5: sweep every code, up from mute and back down under power-down
        for (int r = 0; r < 128; r++) begin
            ramp(7'(r), 1'b0, "R8");
            ramp(7'(r), 1'b1, "R5");
        end

        // R7: request change mid-ramp
        for (int i = 0; i < 40; i++) drive(7'd100, 1'b1, 1'b0, 1'b0, "R7");
        chk("R7", "mid_level", int'(gain_code), 39);
        ramp(7'd10, 1'b0, "R7");
        for (int i = 0; i < 5; i++) drive(7'd90, 1'b1, 1'b0, 1'b0, "R7");
        chk("R7", "turned_up", int'(gain_code), 15);

        // R6/R8: power-down released before mute, ramp resumes upward
        for (int i = 0; i < 6; i++) drive(7'd90, 1'b1, 1'b0, 1'b1, "R6");
        chk("R6", "busy_mid_ramp", int'(pdn_busy), 1);
        ramp(7'd90, 1'b0, "R8");

        // R4: bypass jumps, including to and from mute
        drive(7'd0, 1'b0, 1'b1, 1'b0, "R4");
        drive(7'd127, 1'b0, 1'b1, 1'b0, "R4");
        chk("R4", "jump_top", int'(gain_code), 127);
        drive(7'd127, 1'b1, 1'b1, 1'b1, "R4");
        chk("R4", "jump_mute", int'(gain_mute), 1);
        drive(7'd64, 1'b0, 1'b1, 1'b0, "R4");
        for (int i = 0; i < 128; i++) drive(7'(i), 1'(i % 3 == 0), 1'b1, 1'(i % 7 == 0), "R4");

        // R2: no strobe means no movement
        for (int i = 0; i < 10; i++) drive(7'd5, 1'b0, 1'b0, 1'b0, "R2");
        summary();
    end
endmodule